// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Engine

This block is the host side of a three-wire serial EEPROM link. It drives chip select, the serial clock and the data line toward the memory and samples the data line coming back. A one-cycle request carries a command, an address, write data and a word-size select. The engine assembles the serial frame itself and derives the serial clock from the system clock. When the command finishes it returns a single-cycle completion pulse, with read data or a timeout flag.

Each frame opens with a start bit and a two-bit opcode, followed by the address and then any write data. Four housekeeping commands share opcode `00` and are told apart by the top two address bits. The width of the address field depends on the word size. After a command that programs the array, the engine releases chip select, waits the minimum low time, raises it again and watches the returned data line for the ready level. It gives up after a bounded number of cycles. Chip select is always held low for a programmable minimum between sessions.

Top module: `mw_host`

## Requirements
- R1: Every frame is, MSB first: a 1 start bit, a 2-bit opcode (read `10`, write `01`, erase `11`), then the address. For write, the data word follows the address.
- R2: Enable, disable, erase-all and write-all are sent with opcode `00`. The top two address bits are `11`, `00`, `10` and `01` respectively, and the remaining address bits are 0. Write-all appends the data word.
- R3: With `req_wide`=0 the frame carries all 7 address bits and 8 data bits. With `req_wide`=1 it carries `req_addr[5:0]` and 16 data bits.
- R4: The serial clock stays high for exactly `HALF_CYC` system cycles and low for exactly `HALF_CYC` cycles between rises within a frame. It is low whenever chip select is low.
- R5: The data line toward the memory changes only while the serial clock is low. The returned data line is sampled at each rising serial clock edge.
- R6: A read sends 1+W extra clock periods after the address (W = 8 or 16). The first sampled bit, a dummy, is dropped. `rd_data` returns the W data bits MSB first, zero-extended when W = 8.
- R7: Chip select stays low for at least `CS_LOW_CYC` system cycles before every rise.
- R8: Write, erase, erase-all and write-all are followed by a separate chip-select session with no serial clock. That session lasts until the returned line reads 1, and `done` comes only then. Read, enable and disable complete without this session.
- R9: If the returned line has not read 1 after `BUSY_TMO_CYC` cycles of polling, the command ends with `done` and `timeout_err` both high.
- R10: A request is taken only while `idle` is high, and `req_valid` has no effect otherwise. `done` is a pulse lasting one system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_cmd | input | 3 | Command: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all |
| req_addr | input | ADDR_BITS | Word address |
| req_wdata | input | 16 | Write data (low 8 bits in 8-bit mode) |
| req_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| idle | output | 1 | Engine ready for a request |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Set with done when the ready poll expired |
| rd_data | output | 16 | Data returned by the last read |
| cs_o | output | 1 | Chip select to the memory |
| sk_o | output | 1 | Serial clock to the memory |
| di_o | output | 1 | Serial data toward the memory |
| do_i | input | 1 | Serial data and ready status from the memory |

## Verification
The assertions assume that `do_i` is a synchronous, glitch-free level. Each request must be stable for the single cycle in which it is taken. The bench keeps to this with a behavioural memory model that updates its output only after a rising serial clock edge or on the system clock, and with a driver that changes requests on the falling system clock edge. The model holds its ready output low for a chosen number of cycles after each programming frame, which exercises both a normal poll and an expired one. One intruding request is held high while a read is still in progress.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int WORD_W = 16;
    localparam int HDR_W  = 3;

    typedef enum logic [2:0] {
        MW_READ      = 3'd0,
        MW_WRITE     = 3'd1,
        MW_ERASE     = 3'd2,
        MW_WREN      = 3'd3,
        MW_WRDIS     = 3'd4,
        MW_ERASE_ALL = 3'd5,
        MW_WRITE_ALL = 3'd6
    } mw_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOW, ST_HIGH, ST_GAP, ST_POLL, ST_REST
    } mw_state_e;

    function automatic logic [1:0] op_of(mw_cmd_e c);
        case (c)
            MW_READ:  return 2'b10;
            MW_WRITE: return 2'b01;
            MW_ERASE: return 2'b11;
            default:  return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] sub_of(mw_cmd_e c);
        case (c)
            MW_WREN:      return 2'b11;
            MW_ERASE_ALL: return 2'b10;
            MW_WRITE_ALL: return 2'b01;
            default:      return 2'b00;
        endcase
    endfunction

    function automatic logic carries_data(mw_cmd_e c);
        return (c == MW_WRITE) || (c == MW_WRITE_ALL);
    endfunction

    function automatic logic is_prog(mw_cmd_e c);
        return (c == MW_WRITE) || (c == MW_ERASE) ||
               (c == MW_ERASE_ALL) || (c == MW_WRITE_ALL);
    endfunction

endpackage

// File: rtl/mw_frame_build.sv
module mw_frame_build
    import mw_pkg::*;
#(
    parameter int AW = 7,
    localparam int FW = HDR_W + AW + WORD_W - 1,
    localparam int CW = $clog2(FW + 2)
) (
    input  mw_cmd_e            cmd,
    input  logic [AW-1:0]      addr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               wide,
    output logic [FW-1:0]      frame,
    output logic [CW-1:0]      nbits
);
    logic [HDR_W-1:0]  hdr;
    logic [WORD_W-1:0] dat;
    logic [AW-1:0]     a_n;
    logic [AW-2:0]     a_w;
    logic [CW-1:0]     dlen, alen, tail;
    logic              spec;

    always_comb begin
        hdr  = {1'b1, op_of(cmd)};
        spec = (op_of(cmd) == 2'b00);
        dat  = carries_data(cmd) ? wdata : '0;
        a_n  = spec ? {sub_of(cmd), {(AW-2){1'b0}}} : addr;
        a_w  = spec ? {sub_of(cmd), {(AW-3){1'b0}}} : addr[AW-2:0];
        dlen = wide ? CW'(WORD_W) : CW'(WORD_W / 2);
        alen = wide ? CW'(AW - 1) : CW'(AW);
        if (wide) frame = {hdr, a_w, dat};
        else      frame = {hdr, a_n, dat[WORD_W/2-1:0], {(WORD_W/2-1){1'b0}}};
        if (carries_data(cmd))    tail = dlen;
        else if (cmd == MW_READ)  tail = dlen + CW'(1);
        else                      tail = '0;
        nbits = CW'(HDR_W) + alen + tail;
    end
endmodule

// File: rtl/mw_bit_shift.sv
module mw_bit_shift
    import mw_pkg::*;
#(
    parameter int FW = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [FW-1:0]     frame_in,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              din,
    output logic              msb,
    output logic [WORD_W-1:0] cap
);
    logic [FW-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            cap  <= '0;
        end else begin
            if (load)          tx_q <= frame_in;
            else if (shift_en) tx_q <= {tx_q[FW-2:0], 1'b0};
            if (sample_en)     cap  <= {cap[WORD_W-2:0], din};
        end
    end

    assign msb = tx_q[FW-1];
endmodule

// File: rtl/mw_host.sv
module mw_host
    import mw_pkg::*;
#(
    parameter int ADDR_BITS    = 7,
    parameter int HALF_CYC     = 25,
    parameter int CS_LOW_CYC   = 25,
    parameter int BUSY_TMO_CYC = 1000000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [2:0]           req_cmd,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic [15:0]          req_wdata,
    input  logic                 req_wide,
    output logic                 idle,
    output logic                 done,
    output logic                 timeout_err,
    output logic [15:0]          rd_data,
    output logic                 cs_o,
    output logic                 sk_o,
    output logic                 di_o,
    input  logic                 do_i
);
    localparam int FW      = HDR_W + ADDR_BITS + WORD_W - 1;
    localparam int CW      = $clog2(FW + 2);
    localparam int CNT_MAX = (HALF_CYC > CS_LOW_CYC) ? HALF_CYC : CS_LOW_CYC;
    localparam int NW      = $clog2(CNT_MAX + 1);
    localparam int TW      = $clog2(BUSY_TMO_CYC + 1);
    localparam int RW      = NW + 1;
    localparam logic [NW-1:0] HALF_M1 = NW'(HALF_CYC - 1);
    localparam logic [NW-1:0] CSL_M1  = NW'(CS_LOW_CYC - 1);
    localparam logic [TW-1:0] TMO_M1  = TW'(BUSY_TMO_CYC - 1);

    mw_state_e         state;
    mw_cmd_e           cmd;
    logic [FW-1:0]     frame;
    logic [CW-1:0]     nbits, bits_q;
    logic [NW-1:0]     cnt_q;
    logic [TW-1:0]     tmo_q;
    logic              cs_q, sk_q, done_q, err_q, prog_q, rd_q, wide_q;
    logic [15:0]       rdata_q;
    logic              load, shift_en, sample_en, msb;
    logic [WORD_W-1:0] cap;

    assign cmd       = mw_cmd_e'(req_cmd);
    assign load      = (state == ST_IDLE) && req_valid;
    assign sample_en = (state == ST_LOW) && (cnt_q == '0);
    assign shift_en  = (state == ST_HIGH) && (cnt_q == '0) && (bits_q != CW'(1));

    mw_frame_build #(.AW(ADDR_BITS)) u_frame (
        .cmd(cmd), .addr(req_addr), .wdata(req_wdata), .wide(req_wide),
        .frame(frame), .nbits(nbits)
    );

    mw_bit_shift #(.FW(FW)) u_shift (
        .clk(clk), .rst(rst), .load(load), .frame_in(frame),
        .shift_en(shift_en), .sample_en(sample_en), .din(do_i),
        .msb(msb), .cap(cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cs_q    <= 1'b0;
            sk_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            prog_q  <= 1'b0;
            rd_q    <= 1'b0;
            wide_q  <= 1'b0;
            rdata_q <= '0;
            cnt_q   <= '0;
            tmo_q   <= '0;
            bits_q  <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    cs_q   <= 1'b1;
                    sk_q   <= 1'b0;
                    bits_q <= nbits;
                    prog_q <= is_prog(cmd);
                    rd_q   <= (cmd == MW_READ);
                    wide_q <= req_wide;
                    cnt_q  <= HALF_M1;
                    state  <= ST_LOW;
                end
                ST_LOW: if (cnt_q == '0) begin
                    sk_q  <= 1'b1;
                    cnt_q <= HALF_M1;
                    state <= ST_HIGH;
                end else cnt_q <= cnt_q - 1'b1;
                ST_HIGH: if (cnt_q == '0) begin
                    sk_q <= 1'b0;
                    if (bits_q == CW'(1)) begin
                        cs_q  <= 1'b0;
                        cnt_q <= CSL_M1;
                        if (prog_q) state <= ST_GAP;
                        else begin
                            done_q <= 1'b1;
                            if (rd_q) rdata_q <= wide_q ? cap : {8'h00, cap[7:0]};
                            state <= ST_REST;
                        end
                    end else begin
                        bits_q <= bits_q - 1'b1;
                        cnt_q  <= HALF_M1;
                        state  <= ST_LOW;
                    end
                end else cnt_q <= cnt_q - 1'b1;
                ST_GAP: if (cnt_q == '0) begin
                    cs_q  <= 1'b1;
                    tmo_q <= '0;
                    state <= ST_POLL;
                end else cnt_q <= cnt_q - 1'b1;
                ST_POLL: if (do_i || tmo_q == TMO_M1) begin
                    cs_q   <= 1'b0;
                    done_q <= 1'b1;
                    err_q  <= !do_i;
                    cnt_q  <= CSL_M1;
                    state  <= ST_REST;
                end else tmo_q <= tmo_q + 1'b1;
                ST_REST: if (cnt_q == '0) state <= ST_IDLE;
                         else cnt_q <= cnt_q - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle        = (state == ST_IDLE);
    assign done        = done_q;
    assign timeout_err = err_q;
    assign rd_data     = rdata_q;
    assign cs_o        = cs_q;
    assign sk_o        = sk_q;
    assign di_o        = cs_q & msb;

    // Run-length counters that observe the pins for the timing properties
    logic [RW-1:0] hi_run, lo_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= RW'(CS_LOW_CYC);
        end else begin
            if (!sk_q) hi_run <= '0;
            else if (hi_run != '1) hi_run <= hi_run + 1'b1;
            if (cs_q) lo_run <= '0;
            else if (lo_run != '1) lo_run <= lo_run + 1'b1;
        end
    end

    assert_sk_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !cs_q |-> !sk_q);
    assert_sk_high_width_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(sk_q) |-> hi_run >= RW'(HALF_CYC));
    assert_di_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (sk_q && $past(sk_q)) |-> $stable(di_o));
    assert_cs_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_q) |-> lo_run >= RW'(CS_LOW_CYC));
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        err_q |-> done_q);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    assert_busy_no_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (!idle && req_valid && state == ST_REST) |=> !cs_q);
endmodule

// File: tb/sim_mw_host.sv
module sim_mw_host;
    import mw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;
    localparam int CSL  = 3;
    localparam int TMO  = 300;
    localparam int AW   = 7;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_wide = 1'b0;
    logic [2:0] req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic idle, done, timeout_err, cs_o, sk_o, di_o, do_i;
    logic [15:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_host #(.ADDR_BITS(AW), .HALF_CYC(HALF), .CS_LOW_CYC(CSL), .BUSY_TMO_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wide(req_wide),
        .idle(idle), .done(done), .timeout_err(timeout_err), .rd_data(rd_data),
        .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_i)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(input logic [6:0] a);
        return {1'b1, a, ~a, 1'b0};
    endfunction

    // ---------------- memory model ----------------
    bit mdl_wide = 0;
    int mdl_busy_cyc = 0;
    int m_n = 0, m_left = 0, busy_left = 0, poll_cnt = 0, exp_polls = 0, alen_m;
    logic [31:0] m_bits = '0;
    logic [15:0] m_word = '0, m_tmp;
    logic m_inread = 0, m_bit = 0, last_prog = 0, cs_d = 0;

    always @(posedge sk_o) if (cs_o) begin
        alen_m = mdl_wide ? 6 : 7;
        m_bits = {m_bits[30:0], di_o};
        m_n++;
        if (m_inread) begin
            if (m_left > 0) begin m_left--; m_bit = m_word[m_left]; end
        end else if (m_n == 3 + alen_m && ((m_bits >> alen_m) & 32'd3) == 32'd2) begin
            m_inread = 1; m_bit = 0;
            m_tmp  = mdl_wide ? pattern({1'b0, m_bits[5:0]}) : pattern(m_bits[6:0]);
            m_word = mdl_wide ? m_tmp : {8'h00, m_tmp[7:0]};
            m_left = mdl_wide ? 16 : 8;
        end
    end

    always @(posedge clk) begin
        if (cs_d && !cs_o && last_prog) busy_left = mdl_busy_cyc;
        else if (busy_left > 0) busy_left--;
        cs_d = cs_o;
    end

    assign do_i = !cs_o ? 1'b0 : (busy_left > 0) ? 1'b0 : (m_inread ? m_bit : 1'b1);

    // ---------------- scoreboard ----------------
    logic [31:0] ef_q[$];
    int en_q[$];
    string et_q[$];
    logic [15:0] rr_q[$];
    bit rchk_q[$], rerr_q[$];
    string rt_q[$];

    int op_m, sub_m;
    always @(negedge cs_o) if (!rst) begin
        if (m_n == 0) begin
            poll_cnt++;
            last_prog = 0;
        end else begin
            op_m  = int'((m_bits >> (m_n - 3)) & 32'd3);
            sub_m = int'((m_bits >> (m_n - 5)) & 32'd3);
            last_prog = (op_m == 1) || (op_m == 3) || (op_m == 0 && (sub_m == 2 || sub_m == 1));
            if (ef_q.size() == 0) chk(0, "R10", "unrequested frame", m_bits, 32'h0);
            else begin
                string t;
                logic [31:0] ev;
                int en;
                ev = ef_q.pop_front(); en = en_q.pop_front(); t = et_q.pop_front();
                chk(m_bits == ev, t, "frame bits", m_bits, ev);
                chk(m_n == en, t, "frame length", m_n, en);
            end
        end
        m_n = 0; m_bits = '0; m_inread = 0;
    end

    logic done_p = 0;
    always @(negedge clk) if (!rst) begin
        if (done && done_p) chk(0, "R10", "done wider than one cycle", 2, 1);
        if (done) begin
            if (rr_q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
            else begin
                string t;
                logic [15:0] er;
                bit cr, ee;
                er = rr_q.pop_front(); cr = rchk_q.pop_front();
                ee = rerr_q.pop_front(); t = rt_q.pop_front();
                if (cr) chk(rd_data == er, "R6", {t, " read data"}, rd_data, er);
                chk(timeout_err == ee, ee ? "R9" : "R8", {t, " timeout flag"}, timeout_err, ee);
                chk(poll_cnt == exp_polls, "R8", {t, " poll sessions"}, poll_cnt, exp_polls);
                if (!ee) chk(busy_left == 0, "R8", {t, " done before ready"}, busy_left, 0);
            end
        end
        done_p = done;
    end

    // ---------------- pin timing monitor ----------------
    int hi_len = 0, lo_len = 0, cs_lo = 100, sk_viol = 0, di_viol = 0, gap_viol = 0;
    logic sk_p = 0, cs_p = 0, di_p = 0;
    always @(negedge clk) if (!rst) begin
        if (sk_o && !cs_o) sk_viol++;
        if (sk_o && !sk_p) begin
            if (lo_len != HALF) sk_viol++;
            hi_len = 1;
        end else if (!sk_o && sk_p) begin
            if (hi_len != HALF) sk_viol++;
            lo_len = cs_o ? 1 : 0;
        end else if (sk_o) hi_len++;
        else if (cs_o) lo_len++;
        else lo_len = 0;
        if (sk_o && sk_p && di_o != di_p) di_viol++;
        if (!cs_o) cs_lo++;
        if (cs_o && !cs_p) begin
            if (cs_lo < CSL) gap_viol++;
            cs_lo = 0;
        end
        sk_p = sk_o; cs_p = cs_o; di_p = di_o;
    end

    // ---------------- driver ----------------
    task automatic send(input mw_cmd_e c, input logic [6:0] a, input logic [15:0] wd,
                        input bit wide, input int busy, input bit exp_err,
                        input bit intrude, input string tag);
        logic [31:0] v;
        int n, al, w, op, sub;
        bit spec, prog;
        logic [6:0] ea;
        logic [15:0] er;
        v = '0; n = 0;
        al = wide ? 6 : 7;
        w  = wide ? 16 : 8;
        case (c)
            MW_READ:  begin op = 2; sub = 0; end
            MW_WRITE: begin op = 1; sub = 0; end
            MW_ERASE: begin op = 3; sub = 0; end
            MW_WREN:  begin op = 0; sub = 3; end
            MW_ERASE_ALL: begin op = 0; sub = 2; end
            MW_WRITE_ALL: begin op = 0; sub = 1; end
            default:  begin op = 0; sub = 0; end
        endcase
        spec = (op == 0);
        prog = (c == MW_WRITE) || (c == MW_ERASE) || (c == MW_ERASE_ALL) || (c == MW_WRITE_ALL);
        ea = spec ? 7'(sub << (al - 2)) : (wide ? {1'b0, a[5:0]} : a);
        v = {v[30:0], 1'b1}; n++;
        v = {v[30:0], op[1]}; n++;
        v = {v[30:0], op[0]}; n++;
        for (int i = al - 1; i >= 0; i--) begin v = {v[30:0], ea[i]}; n++; end
        if (c == MW_WRITE || c == MW_WRITE_ALL)
            for (int i = w - 1; i >= 0; i--) begin v = {v[30:0], wd[i]}; n++; end
        if (c == MW_READ)
            for (int i = 0; i <= w; i++) begin v = {v[30:0], 1'b0}; n++; end
        er = pattern(wide ? {1'b0, a[5:0]} : a);
        if (!wide) er = {8'h00, er[7:0]};
        if (prog) exp_polls++;
        ef_q.push_back(v); en_q.push_back(n); et_q.push_back(tag);
        rr_q.push_back(er); rchk_q.push_back(c == MW_READ);
        rerr_q.push_back(exp_err); rt_q.push_back(tag);

        @(negedge clk);
        while (!idle) @(negedge clk);
        mdl_wide = wide; mdl_busy_cyc = busy;
        req_cmd = c; req_addr = a; req_wdata = wd; req_wide = wide; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            chk(idle == 1'b0, "R10", "idle while busy", idle, 0);
            req_cmd = MW_WRITE; req_addr = 7'h11; req_wdata = 16'hFFFF; req_valid = 1'b1;
            repeat (6) @(negedge clk);
            req_valid = 1'b0;
        end
        while (!idle) @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_o == 1'b0, "R4", "reset cs", cs_o, 0);
        chk(sk_o == 1'b0, "R4", "reset sk", sk_o, 0);
        chk(done == 1'b0, "R10", "reset done", done, 0);
        chk(idle == 1'b1, "R10", "reset idle", idle, 1);

        send(MW_WREN,      7'h00, 16'h0000, 0, 0, 0, 0, "R2 enable narrow");
        send(MW_READ,      7'h55, 16'h0000, 0, 0, 0, 0, "R1 R3 read narrow");
        send(MW_READ,      7'h6A, 16'h0000, 1, 0, 0, 0, "R3 read wide");
        send(MW_WRITE,     7'h23, 16'h00C3, 0, 40, 0, 0, "R1 write narrow");
        send(MW_WRITE,     7'h7F, 16'hBEEF, 1, 25, 0, 0, "R3 write wide");
        send(MW_ERASE,     7'h01, 16'h0000, 0, 10, 0, 0, "R1 erase narrow");
        send(MW_ERASE_ALL, 7'h3C, 16'h0000, 1, 30, 0, 0, "R2 erase-all wide");
        send(MW_WRITE_ALL, 7'h00, 16'h00A5, 0, 15, 0, 0, "R2 write-all narrow");
        send(MW_WRDIS,     7'h7F, 16'h0000, 1, 0, 0, 0, "R2 disable wide");
        send(MW_WRITE,     7'h40, 16'h005A, 0, TMO + 100, 1, 0, "R9 write timeout");
        repeat (150) @(negedge clk);
        send(MW_READ,      7'h2B, 16'h0000, 0, 0, 0, 1, "R10 read with intruder");
        send(MW_READ,      7'h15, 16'h0000, 1, 0, 0, 0, "R6 read wide again");

        repeat (10) @(negedge clk);
        chk(ef_q.size() == 0 && rr_q.size() == 0, "R10", "scoreboard drained",
            ef_q.size() + rr_q.size(), 0);
        chk(sk_viol == 0, "R4", "serial clock phase violations", sk_viol, 0);
        chk(di_viol == 0, "R5", "data changes while clock high", di_viol, 0);
        chk(gap_viol == 0, "R7", "short chip-select gaps", gap_viol, 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule